// File: doc/BRIEF.md
# Interlocked Frame Receive Handshake Controller

This block handles the receive side of interlocked frames on one port of a serial storage link. Software reserves a small set of receive slots. Each reservation carries a control word and the byte counts of its scatter segments. Every frame that arrives is first checked against a programmable frame-type mask. A frame whose type is enabled is then judged: it is either captured into the lowest-numbered reserved slot, or refused.

A captured frame produces a completion pulse that carries the slot index and the received byte count, and the slot is released. The link acknowledge for a captured frame is held back until the host writes an accept or reject decision, unless auto-accept has been switched on. While the acknowledge is held, the frame input stalls. With auto-accept on, an enabled frame that finds no reserved slot is acknowledged as good and dropped. Moving the frame body into memory and the link primitives are handled elsewhere.

Top module: `ilk_rx_ctrl`

## Requirements
- R1: After reset, no acknowledge or completion is pending, `frm_ready` is high, no slot is reserved, the type mask is all zero and auto-accept is off.
- R2: A reservation write makes the addressed slot a receive slot only when bit 3 of `resv_ctrl` is 1; with bit 3 at 0 the slot is left unreserved. The slot's capacity is the sum of the `NUM_SEG` segment counts (segment k in `resv_seg_cnt[k*LEN_W +: LEN_W]`).
- R3: A frame whose type bit in the mask is 0 is taken from the stream and produces neither acknowledge nor completion.
- R4: An enabled frame with `frm_err` set gets an ERR acknowledge (`ack_code` = 2'b10; OK is 2'b01) one cycle after it is taken, with no completion, and any reserved slot stays reserved.
- R5: An enabled error-free frame whose length exceeds the chosen slot's capacity gets an ERR acknowledge and no completion, and the slot stays reserved. A length equal to the capacity is captured.
- R6: A captured frame raises `cmp_valid` one cycle after it is taken, with `cmp_slot` set to the lowest reserved slot index and `cmp_count` set to the frame length. That slot is then free.
- R7: With auto-accept off, no acknowledge follows a capture and `frm_ready` stays low until a host decision write.
- R8: While a decision is awaited, a host write with bit 12 set gives an OK acknowledge on the next cycle. A write with bit 11 set gives ERR, and bit 11 wins if both are set. `frm_ready` returns high in that same cycle.
- R9: Host writes of bits 11 or 12 while no decision is awaited produce no acknowledge.
- R10: A host write with bit 14 set turns auto-accept on. From then on, a capture gives an OK acknowledge in the same cycle as its completion, and `frm_ready` stays high.
- R11: An enabled error-free frame that finds no reserved slot is acknowledged OK with no completion when auto-accept is on, and ERR when it is off.
- R12: If a reservation write and a capture address the same slot at the same clock edge, the reservation wins: the slot stays reserved with the new capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the frame-type mask |
| cfg_type_mask | input | NUM_TYPES | One enable bit per frame type |
| host_wr | input | 1 | Host control-set write strobe |
| host_wdata | input | HOST_W | Control-set data: bit 11 reject, bit 12 accept, bit 14 auto-accept |
| resv_valid | input | 1 | Slot reservation write strobe |
| resv_slot | input | SLOT_W | Slot addressed by the reservation |
| resv_ctrl | input | CTL_W | Slot control word; bit 3 marks a receive slot |
| resv_seg_cnt | input | NUM_SEG*LEN_W | Packed segment byte counts |
| frm_valid | input | 1 | Frame arrival valid |
| frm_ready | output | 1 | Frame can be taken; low while a decision is awaited |
| frm_type | input | TYPE_W | Frame type code |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_err | input | 1 | Frame arrived with an error |
| ack_valid | output | 1 | One-cycle acknowledge pulse |
| ack_code | output | 2 | 2'b01 OK, 2'b10 ERR |
| cmp_valid | output | 1 | One-cycle slot completion pulse |
| cmp_slot | output | SLOT_W | Completed slot index |
| cmp_count | output | LEN_W | Bytes received into the completed slot |

## Verification
Two functions can land on the same clock edge. One is the release of a slot by a capture; the other is a fresh reservation of that same slot. The bench provokes this by driving a reservation of slot 0 with a larger capacity in the very cycle a frame is taken into slot 0. It then judges the outcome with a second frame whose length fits only the new capacity: that frame must complete into slot 0, not be refused. In auto-accept mode, completion and acknowledge also share a cycle, and the bench requires both pulses together with an OK code.

// File: rtl/ilk_rx_pkg.sv
package ilk_rx_pkg;

    // Control-word and host-write bit positions
    localparam int CTL_RX_BIT     = 3;
    localparam int HC_REJECT_BIT  = 11;
    localparam int HC_ACCEPT_BIT  = 12;
    localparam int HC_AUTO_BIT    = 14;

    typedef enum logic [1:0] {
        ACK_NONE = 2'b00,
        ACK_OK   = 2'b01,
        ACK_ERR  = 2'b10
    } ack_code_e;

    typedef enum logic [1:0] {
        VD_IGNORE,
        VD_REJECT,
        VD_DISCARD,
        VD_CAPTURE
    } verdict_e;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic      valid;
        ack_code_e code;
    } ack_t;

    // Reject has priority over accept when both are written
    function automatic ack_code_e decision_code(input logic rej, input logic acc);
        if (rej)      return ACK_ERR;
        else if (acc) return ACK_OK;
        else          return ACK_NONE;
    endfunction

endpackage

// File: rtl/ilk_slot_table.sv
module ilk_slot_table
    import ilk_rx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int LEN_W     = 16,
    parameter int NUM_SEG   = 2,
    parameter int CAP_W     = 17
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     resv_valid,
    input  logic [SLOT_W-1:0]        resv_slot,
    input  logic                     resv_rx_flag,
    input  logic [NUM_SEG*LEN_W-1:0] resv_seg_cnt,
    input  logic                     rel_valid,
    input  logic [SLOT_W-1:0]        rel_slot,
    output logic                     any_rsv,
    output logic [SLOT_W-1:0]        pick_slot,
    output logic [CAP_W-1:0]         pick_cap
);

    logic [CAP_W-1:0]     new_cap;
    logic [NUM_SLOTS-1:0] rsv_vec;
    logic [CAP_W-1:0]     cap_arr [NUM_SLOTS];

    always_comb begin
        new_cap = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            new_cap = new_cap + CAP_W'(resv_seg_cnt[s*LEN_W +: LEN_W]);
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic             r_q;
        logic [CAP_W-1:0] c_q;
        logic             hit_resv;
        logic             hit_rel;

        assign hit_resv = resv_valid && (resv_slot == SLOT_W'(g));
        assign hit_rel  = rel_valid  && (rel_slot  == SLOT_W'(g));

        // A reservation at the same edge as a release wins
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= 1'b0;
                c_q <= '0;
            end else if (hit_resv) begin
                r_q <= resv_rx_flag;
                c_q <= new_cap;
            end else if (hit_rel) begin
                r_q <= 1'b0;
            end
        end

        assign rsv_vec[g] = r_q;
        assign cap_arr[g] = c_q;
    end

    // Lowest reserved index is consumed first
    always_comb begin
        pick_slot = '0;
        pick_cap  = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (rsv_vec[s]) begin
                pick_slot = SLOT_W'(s);
                pick_cap  = cap_arr[s];
            end
        end
    end

    assign any_rsv = |rsv_vec;

endmodule

// File: rtl/ilk_frame_judge.sv
module ilk_frame_judge
    import ilk_rx_pkg::*;
#(
    parameter int TYPE_W    = 3,
    parameter int NUM_TYPES = 8,
    parameter int LEN_W     = 16,
    parameter int CAP_W     = 17
) (
    input  logic [TYPE_W-1:0]    frm_type,
    input  logic [LEN_W-1:0]     frm_len,
    input  logic                 frm_err,
    input  logic [NUM_TYPES-1:0] type_mask,
    input  logic                 any_rsv,
    input  logic [CAP_W-1:0]     pick_cap,
    input  logic                 auto_on,
    output verdict_e             verdict
);

    logic type_on;
    logic too_long;

    assign type_on  = type_mask[frm_type];
    assign too_long = CAP_W'(frm_len) > pick_cap;

    always_comb begin
        if (!type_on)
            verdict = VD_IGNORE;
        else if (frm_err)
            verdict = VD_REJECT;
        else if (!any_rsv)
            verdict = auto_on ? VD_DISCARD : VD_REJECT;
        else if (too_long)
            verdict = VD_REJECT;
        else
            verdict = VD_CAPTURE;
    end

endmodule

// File: rtl/ilk_ack_fsm.sv
module ilk_ack_fsm
    import ilk_rx_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  verdict_e          verdict,
    input  logic [SLOT_W-1:0] pick_slot,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              auto_on,
    input  logic              dec_wr,
    input  logic              dec_rej,
    input  logic              dec_acc,
    output logic              idle,
    output logic              rel_valid,
    output logic [SLOT_W-1:0] rel_slot,
    output ack_t              ack_q,
    output logic              cmp_valid,
    output logic [SLOT_W-1:0] cmp_slot,
    output logic [LEN_W-1:0]  cmp_count
);

    rx_state_e state_q, state_d;
    ack_t      ack_d;
    ack_code_e dec_code;

    assign idle      = (state_q == ST_IDLE);
    assign rel_valid = fire && (verdict == VD_CAPTURE);
    assign rel_slot  = pick_slot;
    assign dec_code  = decision_code(dec_rej, dec_acc);

    always_comb begin
        state_d = state_q;
        ack_d   = '{valid: 1'b0, code: ACK_NONE};
        if (state_q == ST_IDLE) begin
            if (fire) begin
                unique case (verdict)
                    VD_REJECT:  ack_d = '{valid: 1'b1, code: ACK_ERR};
                    VD_DISCARD: ack_d = '{valid: 1'b1, code: ACK_OK};
                    VD_CAPTURE: begin
                        if (auto_on) ack_d   = '{valid: 1'b1, code: ACK_OK};
                        else         state_d = ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end else begin
            if (dec_wr && dec_code != ACK_NONE) begin
                ack_d   = '{valid: 1'b1, code: dec_code};
                state_d = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ack_q     <= '{valid: 1'b0, code: ACK_NONE};
            cmp_valid <= 1'b0;
            cmp_slot  <= '0;
            cmp_count <= '0;
        end else begin
            state_q   <= state_d;
            ack_q     <= ack_d;
            cmp_valid <= rel_valid;
            if (rel_valid) begin
                cmp_slot  <= pick_slot;
                cmp_count <= frm_len;
            end
        end
    end

endmodule

// File: rtl/ilk_rx_ctrl.sv
module ilk_rx_ctrl
    import ilk_rx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int LEN_W     = 16,
    parameter int NUM_SEG   = 2,
    parameter int TYPE_W    = 3,
    parameter int CTL_W     = 8,
    parameter int HOST_W    = 16,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int NUM_TYPES = 1 << TYPE_W,
    localparam int CAP_W     = LEN_W + $clog2(NUM_SEG + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [NUM_TYPES-1:0]     cfg_type_mask,
    input  logic                     host_wr,
    input  logic [HOST_W-1:0]        host_wdata,
    input  logic                     resv_valid,
    input  logic [SLOT_W-1:0]        resv_slot,
    input  logic [CTL_W-1:0]         resv_ctrl,
    input  logic [NUM_SEG*LEN_W-1:0] resv_seg_cnt,
    input  logic                     frm_valid,
    output logic                     frm_ready,
    input  logic [TYPE_W-1:0]        frm_type,
    input  logic [LEN_W-1:0]         frm_len,
    input  logic                     frm_err,
    output logic                     ack_valid,
    output logic [1:0]               ack_code,
    output logic                     cmp_valid,
    output logic [SLOT_W-1:0]        cmp_slot,
    output logic [LEN_W-1:0]         cmp_count
);

    logic [NUM_TYPES-1:0] mask_q;
    logic                 auto_q;
    logic                 fire;
    logic                 any_rsv;
    logic [SLOT_W-1:0]    pick_slot;
    logic [CAP_W-1:0]     pick_cap;
    logic                 rel_valid;
    logic [SLOT_W-1:0]    rel_slot;
    verdict_e             verdict;
    ack_t                 ack_q;
    logic                 idle;

    // Bits of the control words that this block does not decode
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{host_wdata, resv_ctrl};

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            auto_q <= 1'b0;
        end else begin
            if (cfg_wr) mask_q <= cfg_type_mask;
            if (host_wr && host_wdata[HC_AUTO_BIT]) auto_q <= 1'b1;
        end
    end

    assign frm_ready = idle;
    assign fire      = frm_valid && frm_ready;

    ilk_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .LEN_W     (LEN_W),
        .NUM_SEG   (NUM_SEG),
        .CAP_W     (CAP_W)
    ) i_slots (
        .clk          (clk),
        .rst          (rst),
        .resv_valid   (resv_valid),
        .resv_slot    (resv_slot),
        .resv_rx_flag (resv_ctrl[CTL_RX_BIT]),
        .resv_seg_cnt (resv_seg_cnt),
        .rel_valid    (rel_valid),
        .rel_slot     (rel_slot),
        .any_rsv      (any_rsv),
        .pick_slot    (pick_slot),
        .pick_cap     (pick_cap)
    );

    ilk_frame_judge #(
        .TYPE_W    (TYPE_W),
        .NUM_TYPES (NUM_TYPES),
        .LEN_W     (LEN_W),
        .CAP_W     (CAP_W)
    ) i_judge (
        .frm_type  (frm_type),
        .frm_len   (frm_len),
        .frm_err   (frm_err),
        .type_mask (mask_q),
        .any_rsv   (any_rsv),
        .pick_cap  (pick_cap),
        .auto_on   (auto_q),
        .verdict   (verdict)
    );

    ilk_ack_fsm #(
        .SLOT_W (SLOT_W),
        .LEN_W  (LEN_W)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .verdict   (verdict),
        .pick_slot (pick_slot),
        .frm_len   (frm_len),
        .auto_on   (auto_q),
        .dec_wr    (host_wr),
        .dec_rej   (host_wdata[HC_REJECT_BIT]),
        .dec_acc   (host_wdata[HC_ACCEPT_BIT]),
        .idle      (idle),
        .rel_valid (rel_valid),
        .rel_slot  (rel_slot),
        .ack_q     (ack_q),
        .cmp_valid (cmp_valid),
        .cmp_slot  (cmp_slot),
        .cmp_count (cmp_count)
    );

    assign ack_valid = ack_q.valid;
    assign ack_code  = ack_q.code;

endmodule

// File: rtl/ilk_rx_checker.sv
module ilk_rx_checker #(
    parameter int SLOT_W = 2,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              frm_valid,
    input logic              frm_ready,
    input logic [LEN_W-1:0]  frm_len,
    input logic              ack_valid,
    input logic [1:0]        ack_code,
    input logic              cmp_valid,
    input logic [SLOT_W-1:0] cmp_slot,
    input logic [LEN_W-1:0]  cmp_count
);

    logic [SLOT_W-1:0] unused_slot;
    assign unused_slot = cmp_slot;

    AST_ACK_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_code == 2'b01 || ack_code == 2'b10)); // R4

    AST_ERR_NO_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_code == 2'b10) |-> !cmp_valid); // R5

    AST_CMP_COUNT: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> ($past(frm_valid && frm_ready) && cmp_count == $past(frm_len))); // R6

    AST_HOLD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !ack_valid) |-> !frm_ready); // R7

    AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!frm_ready && !host_wr) |=> !frm_ready); // R7

    AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (frm_ready && !frm_valid) |=> (!ack_valid && !cmp_valid)); // R9

    AST_AUTO_OK_WITH_CMP: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && ack_valid) |-> ack_code == 2'b01); // R10

endmodule

bind ilk_rx_ctrl ilk_rx_checker #(
    .SLOT_W (SLOT_W),
    .LEN_W  (LEN_W)
) i_chk (.*);

// File: tb/test_ilk_rx_ctrl.sv
module test_ilk_rx_ctrl;

    localparam int NUM_SLOTS = 4;
    localparam int LEN_W     = 16;
    localparam int NUM_SEG   = 2;
    localparam int TYPE_W    = 3;
    localparam int CTL_W     = 8;
    localparam int HOST_W    = 16;
    localparam int SLOT_W    = 2;
    localparam int NUM_TYPES = 8;

    localparam logic [1:0] OK  = 2'b01;
    localparam logic [1:0] ERR = 2'b10;
    localparam logic [HOST_W-1:0] W_REJ  = 16'h0800;
    localparam logic [HOST_W-1:0] W_ACC  = 16'h1000;
    localparam logic [HOST_W-1:0] W_AUTO = 16'h4000;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     cfg_wr = 1'b0;
    logic [NUM_TYPES-1:0]     cfg_type_mask = '0;
    logic                     host_wr = 1'b0;
    logic [HOST_W-1:0]        host_wdata = '0;
    logic                     resv_valid = 1'b0;
    logic [SLOT_W-1:0]        resv_slot = '0;
    logic [CTL_W-1:0]         resv_ctrl = '0;
    logic [NUM_SEG*LEN_W-1:0] resv_seg_cnt = '0;
    logic                     frm_valid = 1'b0;
    logic                     frm_ready;
    logic [TYPE_W-1:0]        frm_type = '0;
    logic [LEN_W-1:0]         frm_len = '0;
    logic                     frm_err = 1'b0;
    logic                     ack_valid;
    logic [1:0]               ack_code;
    logic                     cmp_valid;
    logic [SLOT_W-1:0]        cmp_slot;
    logic [LEN_W-1:0]         cmp_count;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    logic             o_ack, o_cmp, o_rdy;
    logic [1:0]       o_code;
    logic [SLOT_W-1:0] o_slot;
    logic [LEN_W-1:0] o_cnt;

    always #10 clk = ~clk;

    ilk_rx_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .LEN_W     (LEN_W),
        .NUM_SEG   (NUM_SEG),
        .TYPE_W    (TYPE_W),
        .CTL_W     (CTL_W),
        .HOST_W    (HOST_W)
    ) i_ilk_rx_ctrl (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample();
        o_ack  = ack_valid;
        o_code = ack_code;
        o_cmp  = cmp_valid;
        o_slot = cmp_slot;
        o_cnt  = cmp_count;
        o_rdy  = frm_ready;
    endtask

    // Check the pulses seen in the cycle after a stimulus
    task automatic expect_out(input string req, input logic ack, input logic [1:0] code,
                              input logic cmp, input logic [SLOT_W-1:0] slot,
                              input logic [LEN_W-1:0] cnt, input logic rdy);
        chk({req, " ack_valid"}, o_ack, ack);
        if (ack) chk({req, " ack_code"}, o_code, code);
        chk({req, " cmp_valid"}, o_cmp, cmp);
        if (cmp) begin
            chk({req, " cmp_slot"}, o_slot, slot);
            chk({req, " cmp_count"}, o_cnt, cnt);
        end
        chk({req, " frm_ready"}, o_rdy, rdy);
    endtask

    task automatic send(input logic [TYPE_W-1:0] t, input logic [LEN_W-1:0] len, input logic err);
        @(negedge clk);
        frm_valid = 1'b1; frm_type = t; frm_len = len; frm_err = err;
        @(negedge clk);
        frm_valid = 1'b0; frm_err = 1'b0;
        sample();
    endtask

    task automatic host(input logic [HOST_W-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
        sample();
    endtask

    task automatic reserve(input logic [SLOT_W-1:0] s, input logic [CTL_W-1:0] c,
                           input logic [LEN_W-1:0] s0, input logic [LEN_W-1:0] s1);
        @(negedge clk);
        resv_valid = 1'b1; resv_slot = s; resv_ctrl = c; resv_seg_cnt = {s1, s0};
        @(negedge clk);
        resv_valid = 1'b0;
    endtask

    task automatic t_reset();
        sample();
        expect_out("R1 reset", 1'b0, OK, 1'b0, 0, 0, 1'b1);
        send(3'd2, 16'd4, 1'b0);  // mask is zero after reset
        expect_out("R1 mask cleared", 1'b0, OK, 1'b0, 0, 0, 1'b1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_type_mask = 8'b0010_0100;  // types 2 and 5
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_mask();
        send(3'd3, 16'd4, 1'b0);
        expect_out("R3 disabled type", 1'b0, OK, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_noslot_err();
        send(3'd2, 16'd4, 1'b0);
        expect_out("R11 no slot manual", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_reserve_flag();
        reserve(2'd1, 8'h00, 16'd10, 16'd6);
        send(3'd5, 16'd4, 1'b0);
        expect_out("R2 flag clear not reserved", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
        reserve(2'd1, 8'h08, 16'd10, 16'd6);
        send(3'd5, 16'd16, 1'b0);
        expect_out("R2 capacity sum capture", 1'b0, OK, 1'b1, 2'd1, 16'd16, 1'b0);
        repeat (3) @(negedge clk);
        sample();
        expect_out("R7 held awaiting decision", 1'b0, OK, 1'b0, 0, 0, 1'b0);
        host(W_ACC);
        expect_out("R8 accept", 1'b1, OK, 1'b0, 0, 0, 1'b1);
        send(3'd5, 16'd4, 1'b0);
        expect_out("R6 slot freed", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_err();
        reserve(2'd2, 8'h08, 16'd60, 16'd40);
        send(3'd2, 16'd20, 1'b1);
        expect_out("R4 error frame", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
        send(3'd2, 16'd50, 1'b0);
        expect_out("R4 slot kept after error", 1'b0, OK, 1'b1, 2'd2, 16'd50, 1'b0);
        host(W_REJ);
        expect_out("R8 reject", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_len();
        reserve(2'd0, 8'h08, 16'd5, 16'd3);
        send(3'd2, 16'd9, 1'b0);
        expect_out("R5 too long", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
        send(3'd2, 16'd8, 1'b0);
        expect_out("R5 exact fit", 1'b0, OK, 1'b1, 2'd0, 16'd8, 1'b0);
        host(W_ACC);
        expect_out("R8 accept after fit", 1'b1, OK, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_order();
        reserve(2'd3, 8'h08, 16'd30, 16'd0);
        reserve(2'd1, 8'h08, 16'd30, 16'd0);
        send(3'd5, 16'd7, 1'b0);
        expect_out("R6 lowest slot first", 1'b0, OK, 1'b1, 2'd1, 16'd7, 1'b0);
        host(W_ACC);
        expect_out("R8 accept order", 1'b1, OK, 1'b0, 0, 0, 1'b1);
        send(3'd5, 16'd9, 1'b0);
        expect_out("R6 next slot", 1'b0, OK, 1'b1, 2'd3, 16'd9, 1'b0);
        host(W_ACC | W_REJ);
        expect_out("R8 reject wins", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_ignore();
        host(W_ACC);
        expect_out("R9 accept ignored", 1'b0, OK, 1'b0, 0, 0, 1'b1);
        host(W_REJ);
        expect_out("R9 reject ignored", 1'b0, OK, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_same_cycle();
        reserve(2'd0, 8'h08, 16'd4, 16'd0);
        @(negedge clk);
        frm_valid = 1'b1; frm_type = 3'd2; frm_len = 16'd4; frm_err = 1'b0;
        resv_valid = 1'b1; resv_slot = 2'd0; resv_ctrl = 8'h08; resv_seg_cnt = {16'd5, 16'd15};
        @(negedge clk);
        frm_valid = 1'b0; resv_valid = 1'b0;
        sample();
        expect_out("R12 capture", 1'b0, OK, 1'b1, 2'd0, 16'd4, 1'b0);
        host(W_ACC);
        send(3'd2, 16'd20, 1'b0);
        expect_out("R12 reservation kept", 1'b0, OK, 1'b1, 2'd0, 16'd20, 1'b0);
        host(W_ACC);
        expect_out("R12 released", 1'b1, OK, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic t_auto();
        host(W_AUTO);
        expect_out("R10 auto write no ack", 1'b0, OK, 1'b0, 0, 0, 1'b1);
        reserve(2'd2, 8'h08, 16'd20, 16'd10);
        send(3'd5, 16'd12, 1'b0);
        expect_out("R10 auto capture", 1'b1, OK, 1'b1, 2'd2, 16'd12, 1'b1);
        send(3'd5, 16'd12, 1'b0);
        expect_out("R11 no slot auto discard", 1'b1, OK, 1'b0, 0, 0, 1'b1);
        send(3'd2, 16'd12, 1'b1);
        expect_out("R4 error in auto", 1'b1, ERR, 1'b0, 0, 0, 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask();
        t_noslot_err();
        t_reserve_flag();
        t_err();
        t_len();
        t_order();
        t_ignore();
        t_same_cycle();
        t_auto();
        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule